// File: doc/BRIEF.md
# Quadrature Rotary Knob Decoder

This block turns the two raw contact signals of a mechanical incremental rotary knob into a position count and direction strobes. The knob's two channels step through a 2-bit Gray-code cycle. The order in which the channels change shows which way the knob turns. One revolution is 24 detents. Mechanical contacts bounce, so each channel is first brought into the clock domain by a two-flop synchroniser. A channel's filtered value then changes only after the synchronised value has differed from it for a set number of consecutive clock samples.

The decoder counts one detent on every rising edge of filtered channel 0. Filtered channel 1 gives the direction: low means clockwise, high means counter-clockwise. A clockwise detent adds one to an 8-bit two's-complement position and a counter-clockwise detent subtracts one. Each detent also raises the matching strobe for a single clock. Reset returns the position to zero. Reset also makes the filters adopt whatever level the channels hold, so a knob that rests with a channel high does not produce a step once reset is released.

Top module: `quadKnobDecoder`

## Requirements
- R1: Each channel passes through a two-flop synchroniser. A change of the synchronised channel reaches the decoder only after it has held for STABLE_CYCLES consecutive samples. A pulse shorter than that leaves position and strobes unchanged.
- R2: A rising edge of filtered channel 0 (encRaw bit 0) while filtered channel 1 (encRaw bit 1) is low is a clockwise detent and increments knobPos by one. The clockwise channel sequence {bit1,bit0} is 00, 01, 11, 10, 00.
- R3: A rising edge of filtered channel 0 while filtered channel 1 is high is a counter-clockwise detent and decrements knobPos by one. The counter-clockwise sequence {bit1,bit0} is 00, 10, 11, 01, 00.
- R4: Every detent raises exactly one pulse on the matching strobe (stepCw or stepCcw), and that pulse is high for exactly one clock cycle.
- R5: stepCw and stepCcw are never high in the same cycle.
- R6: While rst is high, knobPos is zero and both strobes are low.
- R7: The filters adopt the channel levels present during reset. No detent is reported in the first cycle after reset, and none is reported for a channel that was already high during reset.
- R8: knobPos wraps modulo 256: one counter-clockwise detent from 0 gives 255, and one clockwise detent from 255 gives 0.
- R9: Channel 0 falling edges and channel 1 edges do not change knobPos. A full Gray cycle of four transitions counts as exactly one detent, so 24 clockwise cycles give a position of 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| encRaw | input | 2 | Raw asynchronous knob channels, bit 0 = channel 0, bit 1 = channel 1 |
| knobPos | output | 8 | Two's-complement position relative to reset |
| stepCw | output | 1 | One-cycle clockwise detent strobe |
| stepCcw | output | 1 | One-cycle counter-clockwise detent strobe |

## Verification
Clean clockwise and counter-clockwise Gray cycles show whether the direction is decoded from the right channel level and whether each full cycle counts once rather than per transition. A run of 24 clockwise cycles and steps across the 0/255 boundary show whether the count accumulates correctly and wraps in both directions. Short spikes on channel 0 show whether the filter passes bounce as a false detent. Releasing reset while channel 0 is held high shows whether the filters adopt the reset-time level or see a phantom rising edge.

// File: rtl/quad_knob_pkg.sv
package quad_knob_pkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic cw;
    logic ccw;
  } stepStrobes_t;
endpackage

// File: rtl/chanDebounce.sv
module chanDebounce #(
  parameter int STABLE_CYCLES = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);

  logic syncA, syncB;
  logic [CNT_W-1:0] runCnt;

  // two-flop synchroniser, free running so reset sees the live level
  always_ff @(posedge clk) begin
    syncA <= rawIn;
    syncB <= syncA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cleanOut <= syncB;
      runCnt   <= '0;
    end else if (syncB == cleanOut) begin
      runCnt <= '0;
    end else if (runCnt == LAST) begin
      cleanOut <= syncB;
      runCnt   <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  AST_FILTER_AGREES: assert property (@(posedge clk) disable iff (rst)
    !$stable(cleanOut) |-> ($past(syncB) == cleanOut && $past(runCnt) == LAST)); // R1
endmodule

// File: rtl/quadStepCtrl.sv
module quadStepCtrl
  import quad_knob_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] chanClean,
  output stepStrobes_t      stepStb
);
  logic [NUM_CH-1:0] chanPrev;
  logic primed;
  logic riseCh0;

  assign riseCh0 = chanClean[0] & ~chanPrev[0];

  always_ff @(posedge clk) begin
    chanPrev <= chanClean;
    if (rst) begin
      primed  <= 1'b0;
      stepStb <= '0;
    end else begin
      primed      <= 1'b1;
      stepStb.cw  <= primed & riseCh0 & ~chanClean[1];
      stepStb.ccw <= primed & riseCh0 &  chanClean[1];
    end
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(stepStb.cw && stepStb.ccw)); // R5
  AST_CW_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stepStb.cw |=> !stepStb.cw); // R4
  AST_CCW_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stepStb.ccw |=> !stepStb.ccw); // R4
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!stepStb.cw && !stepStb.ccw)); // R7
endmodule

// File: rtl/quadPosDatapath.sv
module quadPosDatapath
  import quad_knob_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  stepStrobes_t     stepStb,
  output logic [POS_W-1:0] posCount
);
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  always_ff @(posedge clk) begin
    if (rst)              posCount <= '0;
    else if (stepStb.cw)  posCount <= posCount + ONE;
    else if (stepStb.ccw) posCount <= posCount - ONE;
  end

  AST_POS_INC: assert property (@(posedge clk) disable iff (rst)
    stepStb.cw |=> posCount == $past(posCount) + ONE); // R2
  AST_POS_DEC: assert property (@(posedge clk) disable iff (rst)
    stepStb.ccw |=> posCount == $past(posCount) - ONE); // R3
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stepStb.cw && !stepStb.ccw) |=> $stable(posCount)); // R9
endmodule

// File: rtl/quadKnobDecoder.sv
module quadKnobDecoder
  import quad_knob_pkg::*;
#(
  parameter int STABLE_CYCLES = 16384,
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       encRaw,
  output logic [POS_W-1:0] knobPos,
  output logic             stepCw,
  output logic             stepCcw
);
  logic [NUM_CH-1:0] chanClean;
  stepStrobes_t stepStb;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_filt
    chanDebounce #(.STABLE_CYCLES(STABLE_CYCLES)) u_filt (
      .clk(clk), .rst(rst), .rawIn(encRaw[ch]), .cleanOut(chanClean[ch])
    );
  end

  quadStepCtrl u_ctrl (
    .clk(clk), .rst(rst), .chanClean(chanClean), .stepStb(stepStb)
  );

  quadPosDatapath #(.POS_W(POS_W)) u_dp (
    .clk(clk), .rst(rst), .stepStb(stepStb), .posCount(knobPos)
  );

  assign stepCw  = stepStb.cw;
  assign stepCcw = stepStb.ccw;

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (knobPos == '0 && !stepCw && !stepCcw)); // R6
endmodule

// File: tb/quadKnobDecoder_bench.sv
`timescale 1ns / 1ps
module quadKnobDecoder_bench;
  localparam int DEB = 4;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] encRaw = 2'b00;
  logic [7:0] knobPos;
  logic stepCw, stepCcw;

  int vecCount = 0;
  int missCount = 0;
  int cwTotal = 0, ccwTotal = 0, wideSeen = 0, bothSeen = 0;
  logic lastCw = 1'b0, lastCcw = 1'b0;

  always #2.5 clk = ~clk;

  quadKnobDecoder #(.STABLE_CYCLES(DEB), .POS_W(8)) u_quadKnobDecoder (
    .clk(clk), .rst(rst), .encRaw(encRaw),
    .knobPos(knobPos), .stepCw(stepCw), .stepCcw(stepCcw)
  );

  // strobe monitor sampled away from the active edge
  always @(negedge clk) begin
    if (stepCw && !lastCw) cwTotal++;
    if (stepCcw && !lastCcw) ccwTotal++;
    if ((stepCw && lastCw) || (stepCcw && lastCcw)) wideSeen++;
    if (stepCw && stepCcw) bothSeen++;
    lastCw  <= stepCw;
    lastCcw <= stepCcw;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic holdRaw(input logic [1:0] v, input int cycles);
    @(negedge clk);
    encRaw = v;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic stepCwOnce();
    holdRaw(2'b01, HOLD); holdRaw(2'b11, HOLD);
    holdRaw(2'b10, HOLD); holdRaw(2'b00, HOLD);
  endtask

  task automatic stepCcwOnce();
    holdRaw(2'b10, HOLD); holdRaw(2'b11, HOLD);
    holdRaw(2'b01, HOLD); holdRaw(2'b00, HOLD);
  endtask

  task automatic doReset(input logic [1:0] v);
    @(negedge clk);
    encRaw = v;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check(knobPos == 8'd0, "R6 pos in reset", knobPos, 0);
    check(!stepCw && !stepCcw, "R6 strobes in reset", {stepCw, stepCcw}, 0);
    rst = 1'b0;
  endtask

  task automatic testResetState();
    doReset(2'b00);
    repeat (20) @(negedge clk);
    check(knobPos == 8'd0, "R6 pos after reset", knobPos, 0);
  endtask

  task automatic testSingleCw();
    int c0 = cwTotal, k0 = ccwTotal;
    logic [7:0] p0 = knobPos;
    stepCwOnce();
    check(knobPos == p0 + 8'd1, "R2 single cw", knobPos, p0 + 1);
    check(cwTotal - c0 == 1, "R4 one cw pulse", cwTotal - c0, 1);
    check(ccwTotal == k0, "R9 no ccw on cw cycle", ccwTotal - k0, 0);
  endtask

  task automatic testSingleCcw();
    int c0 = cwTotal, k0 = ccwTotal;
    logic [7:0] p0 = knobPos;
    stepCcwOnce();
    check(knobPos == p0 - 8'd1, "R3 single ccw", knobPos, p0 - 1);
    check(ccwTotal - k0 == 1, "R4 one ccw pulse", ccwTotal - k0, 1);
    check(cwTotal == c0, "R9 no cw on ccw cycle", cwTotal - c0, 0);
  endtask

  task automatic testRevolution();
    int c0 = cwTotal;
    doReset(2'b00);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 24; i++) stepCwOnce();
    check(knobPos == 8'd24, "R9 revolution count", knobPos, 24);
    check(cwTotal - c0 == 24, "R4 revolution pulses", cwTotal - c0, 24);
  endtask

  task automatic testWrap();
    doReset(2'b00);
    repeat (4) @(negedge clk);
    stepCcwOnce();
    check(knobPos == 8'd255, "R8 wrap down", knobPos, 255);
    stepCwOnce();
    check(knobPos == 8'd0, "R8 wrap up", knobPos, 0);
  endtask

  task automatic testBounce();
    int c0 = cwTotal, k0 = ccwTotal;
    logic [7:0] p0 = knobPos;
    for (int i = 0; i < 4; i++) begin
      holdRaw(2'b01, DEB - 2);
      holdRaw(2'b00, DEB + 1);
    end
    repeat (20) @(negedge clk);
    check(knobPos == p0, "R1 bounce pos", knobPos, p0);
    check(cwTotal == c0 && ccwTotal == k0, "R1 bounce strobes",
          cwTotal - c0 + ccwTotal - k0, 0);
  endtask

  task automatic testResetHigh();
    int c0 = cwTotal, k0 = ccwTotal;
    doReset(2'b01);
    repeat (30) @(negedge clk);
    check(knobPos == 8'd0, "R7 pos after reset high", knobPos, 0);
    check(cwTotal == c0 && ccwTotal == k0, "R7 no phantom step",
          cwTotal - c0 + ccwTotal - k0, 0);
    holdRaw(2'b00, HOLD);
    check(knobPos == 8'd0, "R9 ch0 fall no step", knobPos, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    missCount++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    testResetState();
    testSingleCw();
    testSingleCcw();
    testSingleCw();
    testSingleCw();
    testBounce();
    testRevolution();
    testWrap();
    testResetHigh();
    testSingleCcw();
    check(wideSeen == 0, "R4 pulse width", wideSeen, 0);
    check(bothSeen == 0, "R5 exclusive strobes", bothSeen, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule